// File: doc/BRIEF.md
# Floating-Point Round-to-Integral Unit

This unit takes a single-precision (binary32) operand and returns the nearest integral value under a chosen rounding direction. The result is still encoded as binary32, so code that needs an integer-valued float can keep it in the floating-point register file. Without this unit, software would convert the value to an integer register and then convert it back.

Each accepted operand comes with a 3-bit rounding-direction code and a variant select. With the select low, the unit runs the quiet variant, whose only possible exception is invalid on a signaling NaN input. With the select high, the unit also reports inexact whenever the result differs from the operand. The unit is a single registered stage. A result appears with its valid strobe one clock after the operand is presented.

Top module: `fp_integral_round`

## Requirements
- R1: While rst_n is low at a rising clock edge, the registered outputs clear: out_valid, out_value, out_invalid, out_inexact and out_bad_mode all become 0.
- R2: out_valid is high in exactly the cycle after a cycle with in_valid high. The output fields change only after a cycle with in_valid high.
- R3: Rounding code 3'b001 (toward zero) discards the fractional part. For example, 2.5 gives 2.0 and -2.7 gives -2.0.
- R4: Rounding code 3'b000 rounds to the nearest integral value, and an exact halfway case goes to the even one. 2.5 gives 2.0, 3.5 gives 4.0 and 0.5 gives 0.0.
- R5: Code 3'b010 rounds toward minus infinity and code 3'b011 rounds toward plus infinity. Code 3'b100 rounds to nearest with halfway cases going away from zero, so 2.5 gives 3.0.
- R6: Three kinds of operand pass through bit-exact with no flags: a biased exponent of 150 or more (an unbiased exponent of at least 23), infinities, and zeros of either sign.
- R7: Any NaN operand yields the canonical NaN 32'h7FC00000. out_invalid is set only when the operand is a signaling NaN, meaning mantissa bit 22 is 0 and the mantissa is non-zero.
- R8: out_inexact is set only when in_signal_inexact was high and the result differs from a finite operand. It is never set for NaN, infinity or already-integral operands.
- R9: Operands of magnitude below 1, including subnormals, produce +/-0 or +/-1 according to the mode and the sign. The sign bit of the result always equals the operand's sign, so -0.3 toward zero gives -0.0 (32'h80000000).
- R10: Rounding codes 3'b101, 3'b110 and 3'b111 set out_bad_mode and return the canonical NaN with out_invalid and out_inexact low. Legal codes leave out_bad_mode low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| in_value | input | 32 | binary32 operand |
| in_rmode | input | 3 | Rounding-direction code |
| in_signal_inexact | input | 1 | 1 selects the inexact-reporting variant |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_value | output | 32 | binary32 integral result |
| out_invalid | output | 1 | Signaling-NaN operand seen |
| out_inexact | output | 1 | Result differs from operand (variant 1 only) |
| out_bad_mode | output | 1 | Rounding code outside the five legal values |

## Verification
The assertions assume the inputs are at known values on every cycle with in_valid high. They also assume each operand and its side inputs are sampled only at the capturing edge, so the properties that compare an output with the previous cycle's inputs look only at cycles that carry a strobe. The stimulus drives all inputs one nanosecond after each rising edge and holds them for the whole cycle. It keeps the random operands fully defined, including during idle cycles. Idle cycles randomize the data lines while in_valid is low, which exercises the hold behaviour those properties rely on.

// File: rtl/fpr_pkg.sv
// fpr_pkg: shared encodings for the round-to-integral unit.
// Assumes: the rounding-direction field is three bits wide.
package fpr_pkg;
    typedef enum logic [2:0] {
        RM_NEAR_EVEN = 3'b000,
        RM_TO_ZERO   = 3'b001,
        RM_DOWN      = 3'b010,
        RM_UP        = 3'b011,
        RM_NEAR_MAX  = 3'b100
    } rmode_e;
endpackage

// File: rtl/fpr_classify.sv
// fpr_classify: sorts an operand by exponent and mantissa into the classes
// the rounding datapath needs.
// Assumes: IEEE-754 interchange layout with a biased exponent.
module fpr_classify #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W-1:0] exp_f,
    input  logic [MAN_W-1:0] man_f,
    output logic             is_nan,
    output logic             is_snan,
    output logic             is_inf,
    output logic             is_zero,
    output logic             is_big,
    output logic             is_small
);
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int INT_EXP = BIAS + MAN_W;

    // Class decode from exponent and mantissa fields.
    always_comb begin
        is_nan   = (&exp_f) && (|man_f);
        is_snan  = is_nan && !man_f[MAN_W-1];
        is_inf   = (&exp_f) && !(|man_f);
        is_zero  = !(|exp_f) && !(|man_f);
        is_big   = !(&exp_f) && (int'(exp_f) >= INT_EXP);
        is_small = !is_zero && (int'(exp_f) < BIAS);
    end
endmodule

// File: rtl/fpr_round_decide.sv
// fpr_round_decide: decides whether the truncated integral part is
// incremented, from guard, sticky, lsb and sign.
// Assumes: the caller already checked the mode code for legality.
module fpr_round_decide (
    input  fpr_pkg::rmode_e mode,
    input  logic            sign,
    input  logic            lsb,
    input  logic            guard,
    input  logic            sticky,
    output logic            bump
);
    // Per-mode increment rule.
    always_comb begin
        unique case (mode)
            fpr_pkg::RM_NEAR_EVEN: bump = guard && (sticky || lsb);
            fpr_pkg::RM_TO_ZERO:   bump = 1'b0;
            fpr_pkg::RM_DOWN:      bump = sign && (guard || sticky);
            fpr_pkg::RM_UP:        bump = !sign && (guard || sticky);
            fpr_pkg::RM_NEAR_MAX:  bump = guard;
            default:               bump = 1'b0;
        endcase
    end
endmodule

// File: rtl/fpr_round_core.sv
// fpr_round_core: combinational round-to-integral datapath. Handles the
// special classes, magnitudes below one, and the in-range shift-round-renormalize path.
// Assumes: the operand is fully defined; the result is registered by the caller.
module fpr_round_core #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] op,
    input  logic [2:0]           mode_code,
    input  logic                 nx_en,
    output logic [EXP_W+MAN_W:0] res,
    output logic                 flag_nv,
    output logic                 flag_nx,
    output logic                 mode_bad
);
    localparam int W       = EXP_W + MAN_W + 1;
    localparam int SIG_W   = MAN_W + 1;
    localparam int SH_W    = $clog2(SIG_W) + 1;
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int INT_EXP = BIAS + MAN_W;
    localparam logic [W-1:0] CANON_NAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

    logic             sgn;
    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;
    assign sgn   = op[W-1];
    assign exp_f = op[W-2:MAN_W];
    assign man_f = op[MAN_W-1:0];

    logic is_nan, is_snan, is_inf, is_zero, is_big, is_small;

    fpr_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
        .exp_f   (exp_f),
        .man_f   (man_f),
        .is_nan  (is_nan),
        .is_snan (is_snan),
        .is_inf  (is_inf),
        .is_zero (is_zero),
        .is_big  (is_big),
        .is_small(is_small)
    );

    logic [SIG_W-1:0] sig, int_part, gv, low_mask;
    logic [SH_W-1:0]  sh;
    logic             lsb_s, guard_s, sticky_s, bump;
    logic [SIG_W:0]   sum, mag;

    // Split the significand into integral part, guard and sticky bits.
    always_comb begin
        sig      = {1'b1, man_f};
        sh       = SH_W'(INT_EXP - int'(exp_f));
        int_part = sig >> sh;
        gv       = sig >> (sh - SH_W'(1));
        low_mask = (SIG_W'(1) << (sh - SH_W'(1))) - SIG_W'(1);
        if (is_small) begin
            lsb_s    = 1'b0;
            guard_s  = (int'(exp_f) == BIAS - 1);
            sticky_s = !guard_s || (|man_f);
        end else begin
            lsb_s    = int_part[0];
            guard_s  = gv[0];
            sticky_s = |(sig & low_mask);
        end
    end

    fpr_round_decide u_dec (
        .mode  (fpr_pkg::rmode_e'(mode_code)),
        .sign  (sgn),
        .lsb   (lsb_s),
        .guard (guard_s),
        .sticky(sticky_s),
        .bump  (bump)
    );

    // Increment, shift back and pick the result for each class.
    always_comb begin
        sum      = {1'b0, int_part} + {{SIG_W{1'b0}}, bump};
        mag      = sum << sh;
        mode_bad = (mode_code > 3'd4);
        flag_nv  = 1'b0;
        flag_nx  = 1'b0;
        if (mode_bad) begin
            res = CANON_NAN;
        end else if (is_nan) begin
            res     = CANON_NAN;
            flag_nv = is_snan;
        end else if (is_inf || is_zero || is_big) begin
            res = op;
        end else if (is_small) begin
            res     = bump ? {sgn, EXP_W'(BIAS), {MAN_W{1'b0}}} : {sgn, {(W-1){1'b0}}};
            flag_nx = nx_en;
        end else begin
            if (mag[SIG_W])
                res = {sgn, exp_f + EXP_W'(1), {MAN_W{1'b0}}};
            else
                res = {sgn, exp_f, mag[MAN_W-1:0]};
            flag_nx = nx_en && (guard_s || sticky_s);
        end
    end
endmodule

// File: rtl/fp_integral_round.sv
// fp_integral_round: one-stage registered round-to-integral unit for binary32.
// It registers the core result and flags on each strobed operand.
// Assumes: inputs are defined whenever in_valid is high; there is no backpressure.
module fp_integral_round #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [EXP_W+MAN_W:0] in_value,
    input  logic [2:0]           in_rmode,
    input  logic                 in_signal_inexact,
    output logic                 out_valid,
    output logic [EXP_W+MAN_W:0] out_value,
    output logic                 out_invalid,
    output logic                 out_inexact,
    output logic                 out_bad_mode
);
    localparam int W = EXP_W + MAN_W + 1;
    localparam logic [W-1:0] CANON_NAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

    logic [W-1:0] core_res;
    logic         core_nv, core_nx, core_bad;

    fpr_round_core #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_core (
        .op       (in_value),
        .mode_code(in_rmode),
        .nx_en    (in_signal_inexact),
        .res      (core_res),
        .flag_nv  (core_nv),
        .flag_nx  (core_nx),
        .mode_bad (core_bad)
    );

    // Output register: clear on reset, load on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_value    <= '0;
            out_invalid  <= 1'b0;
            out_inexact  <= 1'b0;
            out_bad_mode <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_value    <= core_res;
                out_invalid  <= core_nv;
                out_inexact  <= core_nx;
                out_bad_mode <= core_bad;
            end
        end
    end

    logic in_nan, in_snan, in_legal;
    assign in_nan   = (&in_value[W-2:MAN_W]) && (|in_value[MAN_W-1:0]);
    assign in_snan  = in_nan && !in_value[MAN_W-1];
    assign in_legal = (in_rmode <= 3'd4);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_value)); // R2
    AST_NAN_CANON: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_legal && in_nan) |=> (out_value == CANON_NAN)); // R7
    AST_NV_ONLY_SNAN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !(in_legal && in_snan)) |=> !out_invalid); // R7
    AST_QUIET_NO_NX: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_signal_inexact) |=> !out_inexact); // R8
    AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_legal && !in_nan) |=> (out_value[W-1] == $past(in_value[W-1]))); // R9
    AST_BAD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_bad_mode == !$past(in_legal))); // R10
endmodule

// File: tb/fp_integral_round_bench.sv
module fp_integral_round_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_value = '0;
    logic [2:0]  in_rmode = '0;
    logic        in_signal_inexact = 1'b0;
    logic        out_valid, out_invalid, out_inexact, out_bad_mode;
    logic [31:0] out_value;

    int n_checks = 0;
    int n_fail   = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    fp_integral_round u_fp_integral_round (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_value(in_value),
        .in_rmode(in_rmode), .in_signal_inexact(in_signal_inexact),
        .out_valid(out_valid), .out_value(out_value), .out_invalid(out_invalid),
        .out_inexact(out_inexact), .out_bad_mode(out_bad_mode)
    );

    typedef struct packed {
        logic [31:0] value;
        logic        nv;
        logic        nx;
        logic        bad;
    } expect_t;

    expect_t exp_q[$];
    string   tag_q[$];

    // Behavioural reference: scaled fixed-point arithmetic, then rebuild a float.
    function automatic expect_t model(logic [31:0] x, logic [2:0] m, logic nx_en);
        expect_t r;
        int e, p;
        logic [127:0] fix, ip, fr, half, n;
        logic up;
        r = '0;
        e = int'(x[30:23]);
        if (m > 3'd4) begin r.value = 32'h7FC00000; r.bad = 1'b1; return r; end
        if (e == 255) begin
            if (x[22:0] != 0) begin r.value = 32'h7FC00000; r.nv = !x[22]; end
            else r.value = x;
            return r;
        end
        if (e >= 150 || x[30:0] == 0) begin r.value = x; return r; end
        if (e < 104) begin
            ip = '0; fr = 128'd1;
        end else begin
            fix = {104'd0, 1'b1, x[22:0]} << (e - 104);
            ip  = fix >> 46;
            fr  = fix & ((128'd1 << 46) - 128'd1);
        end
        half = 128'd1 << 45;
        case (m)
            3'd0:    up = (fr > half) || (fr == half && ip[0]);
            3'd1:    up = 1'b0;
            3'd2:    up = x[31] && (fr != 0);
            3'd3:    up = !x[31] && (fr != 0);
            default: up = (fr >= half);
        endcase
        n = ip + (up ? 128'd1 : 128'd0);
        if (n == 0) r.value = {x[31], 31'd0};
        else begin
            p = 0;
            for (int i = 0; i < 32; i++) if (n[i]) p = i;
            if (p > 23) r.value = {x[31], 8'(127 + p), 23'(n >> (p - 23))};
            else        r.value = {x[31], 8'(127 + p), 23'(n << (23 - p))};
        end
        r.nx = nx_en && (fr != 0);
        return r;
    endfunction

    task automatic apply(input logic [31:0] x, input logic [2:0] m, input logic nx, input string tag);
        @(posedge clk); #1;
        in_valid = 1'b1; in_value = x; in_rmode = m; in_signal_inexact = nx;
        exp_q.push_back(model(x, m, nx));
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        @(posedge clk); #1;
        in_valid = 1'b0; in_value = $urandom; in_rmode = 3'($urandom); in_signal_inexact = 1'($urandom);
    endtask

    logic sampled_v = 1'b0;
    always @(posedge clk) sampled_v <= rst_n && in_valid;

    // Compare on every clock, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            n_checks++;
            if (out_valid !== sampled_v) begin
                n_fail++;
                $display("FAIL R2 out_valid actual=%b expected=%b", out_valid, sampled_v);
            end
            if (sampled_v && exp_q.size() > 0) begin
                expect_t e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_checks++;
                if ({out_value, out_invalid, out_inexact, out_bad_mode} !== e) begin
                    n_fail++;
                    $display("FAIL %s actual=%h nv%b nx%b bad%b expected=%h nv%b nx%b bad%b",
                             t, out_value, out_invalid, out_inexact, out_bad_mode,
                             e.value, e.nv, e.nx, e.bad);
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        in_valid = 1'b1; in_value = 32'h40200000;
        repeat (3) @(posedge clk);
        #1;
        n_checks++; // R1 reset state
        if ({out_valid, out_value, out_invalid, out_inexact, out_bad_mode} !== 36'd0) begin
            n_fail++;
            $display("FAIL R1 reset outputs actual=%b_%h expected=0_00000000", out_valid, out_value);
        end
        in_valid = 1'b0;
        rst_n = 1'b1;
        // R3 truncation
        apply(32'h40200000, 3'd1, 1'b0, "R3");
        apply(32'hC02CCCCD, 3'd1, 1'b1, "R3");
        // R4 nearest-even ties
        apply(32'h40200000, 3'd0, 1'b0, "R4");
        apply(32'h40600000, 3'd0, 1'b0, "R4");
        apply(32'h3F000000, 3'd0, 1'b0, "R4");
        apply(32'h4AFFFFFF, 3'd0, 1'b1, "R4");
        idle();
        // R5 directed modes and ties away
        apply(32'h40200000, 3'd4, 1'b0, "R5");
        apply(32'h3F000000, 3'd4, 1'b0, "R5");
        apply(32'hC0200000, 3'd2, 1'b0, "R5");
        apply(32'hC0200000, 3'd3, 1'b0, "R5");
        apply(32'h40200000, 3'd3, 1'b0, "R5");
        // R6 pass-through
        apply(32'h4B000001, 3'd3, 1'b1, "R6");
        apply(32'h7F800000, 3'd0, 1'b1, "R6");
        apply(32'hFF800000, 3'd2, 1'b1, "R6");
        apply(32'h80000000, 3'd3, 1'b1, "R6");
        apply(32'h00000000, 3'd2, 1'b1, "R6");
        // R7 NaN handling
        apply(32'h7FC12345, 3'd0, 1'b1, "R7");
        apply(32'h7F800001, 3'd0, 1'b1, "R7");
        apply(32'hFFA00000, 3'd1, 1'b0, "R7");
        // R8 inexact only in variant, only when changed
        apply(32'h3FC00000, 3'd0, 1'b0, "R8");
        apply(32'h3FC00000, 3'd0, 1'b1, "R8");
        apply(32'h40400000, 3'd3, 1'b1, "R8");
        // R9 small magnitudes and sign
        apply(32'hBE99999A, 3'd1, 1'b1, "R9");
        apply(32'h00000001, 3'd3, 1'b1, "R9");
        apply(32'h80000001, 3'd2, 1'b1, "R9");
        apply(32'h80000001, 3'd3, 1'b1, "R9");
        apply(32'hBF400000, 3'd0, 1'b0, "R9");
        // R10 illegal codes
        apply(32'h40200000, 3'd5, 1'b1, "R10");
        apply(32'h7F800001, 3'd6, 1'b1, "R10");
        apply(32'h3F800000, 3'd7, 1'b0, "R10");
        idle(); idle();
        // Random operands with idle gaps, mostly near the integral boundary.
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] x;
            logic [2:0]  m;
            string       t;
            if (($urandom % 4) == 0) x = $urandom;
            else x = {1'($urandom), 8'(100 + ($urandom % 60)), 23'($urandom)};
            m = ($urandom % 8 == 0) ? 3'(5 + $urandom % 3) : 3'($urandom % 5);
            t = (m > 3'd4) ? "R10" : (m == 3'd1) ? "R3" : (m == 3'd0) ? "R4" : "R5";
            apply(x, m, 1'($urandom), t);
            if (($urandom % 5) == 0) idle();
        end
        idle(); idle(); idle();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule